// File: doc/BRIEF.md
# Inclusive L2 Virtual Alias Detector

This block is the control and tag/data storage for a direct-mapped second-level cache that holds a copy of every line in a first-level cache. The L2 is indexed and tagged by physical line address. The L1 above it is indexed partly by virtual address bits, so two virtual pages that map to one physical page could place two copies of the same line in two L1 sets. To prevent this, each L2 entry records which L1 set the line currently sits in. It stores the virtual index bits above the page offset, together with a flag that says whether the line is in L1 at all.

An L1 miss arrives with its translated physical line address and the virtual index bits it used. If the L2 hits but the line is held in L1 under other virtual bits, the block first sends an invalidate for the old L1 set. It waits for the acknowledge, then returns the line for the new set and records the new bits. On an L2 miss it does the same for the victim line before it fetches from memory, so the L2 keeps its copy of every line that L1 holds. L1 reports its own evictions so that the in-L1 flag stays accurate. The block handles one request at a time.

Top module: `l2_alias_guard`

## Requirements
- R1: After reset, reqReady is 1, invValid, memReqValid and respValid are 0, and every L2 entry is invalid, so the first access to any address goes to memory.
- R2: On an L2 miss, exactly one memory read is issued with memReqAddr equal to the request's physical line address. memReqValid and memReqAddr hold until memReqReady. The response follows the memory reply, with respSet = {reqVidx, reqPa[1:0]} (virtual bits above the two page-offset index bits).
- R3: An L2 hit whose line is not in L1, or is in L1 under the same virtual bits, is answered with no memory read and no invalidate.
- R4: An L2 hit whose line is in L1 under different virtual bits issues one invalidate with invSet = {stored virtual bits, reqPa[1:0]}. There is no memory read, and the response is given only after invAck.
- R5: An L2 miss whose victim entry is in L1 invalidates the victim's L1 set ({victim's virtual bits, reqPa[1:0]}) and receives invAck before memReqValid rises.
- R6: An L1 eviction report whose line address matches a valid entry clears that entry's in-L1 flag, so a later access under other virtual bits needs no invalidate.
- R7: reqReady is 1 only when the block is idle. It is 0 from the cycle after a request is accepted through the cycle of the response.
- R8: respData equals the data that memory returned for that physical line address, including on later hits.
- R9: invValid and invSet hold until invAck, and respValid is never 1 while invValid is 1.
- R10: An eviction report whose line address matches no valid entry changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | L1 miss request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqPa | input | 12 | Physical line address of the miss |
| reqVidx | input | 2 | Virtual index bits above the page offset used by L1 |
| evictValid | input | 1 | L1 reports it dropped a line |
| evictPa | input | 12 | Physical line address of the dropped line |
| invValid | output | 1 | Invalidate command to L1 |
| invSet | output | 4 | Full L1 set index to invalidate |
| invAck | input | 1 | L1 has done the invalidate |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 12 | Physical line address to read |
| memRespValid | input | 1 | Memory read data present |
| memRespData | input | 32 | Memory read data |
| respValid | output | 1 | Line returned to L1 (single cycle) |
| respData | output | 32 | Line data |
| respSet | output | 4 | L1 set to fill |

## Verification
Directed sequences on one L2 index cover each case in turn: a cold miss, a same-bits hit, an alias hit, and a conflict miss whose victim is still in L1. Each of these produces a different mix of invalidates and memory reads. Matched and unmatched eviction reports separate a cleared in-L1 flag from an untouched one. Random traffic then draws from a small pool of addresses and virtual bits, so aliases, conflicts and repeat hits interleave, with random memory stalls and acknowledge delays. A bench model predicts the invalidate set, the ordering against the memory read, and the returned data and set for each request.

// File: rtl/l2ag_pkg.sv
package l2ag_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_PURGE,
    ST_MEMFETCH,
    ST_RESPOND
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq; // latch request address and virtual bits
    logic fillLine;   // write memory reply into the indexed entry
    logic markInL1;   // record line as held in L1 under request bits
    logic clearInL1;  // old L1 copy purged
  } dpStrobe_t;

endpackage

// File: rtl/l2ag_datapath.sv
module l2ag_datapath
  import l2ag_pkg::*;
#(
  parameter int PA_W      = 12,
  parameter int L2_IDX_W  = 4,
  parameter int OFF_IDX_W = 2,
  parameter int VBITS     = 2,
  parameter int DATA_W    = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [PA_W-1:0]           reqPaIn,
  input  logic [VBITS-1:0]          reqVidxIn,
  input  logic [DATA_W-1:0]         memRespData,
  input  logic                      evictValid,
  input  logic [PA_W-1:0]           evictPa,
  output logic                      lookupHit,
  output logic                      entryInL1,
  output logic                      vidxDiffers,
  output logic [PA_W-1:0]           lineAddr,
  output logic [VBITS+OFF_IDX_W-1:0] purgeSet,
  output logic [VBITS+OFF_IDX_W-1:0] fillSet,
  output logic [DATA_W-1:0]         lineData
);

  localparam int TAG_W   = PA_W - L2_IDX_W;
  localparam int ENTRIES = 1 << L2_IDX_W;

  logic [PA_W-1:0]     reqPa;
  logic [VBITS-1:0]    reqVidx;

  logic                validArr [ENTRIES];
  logic                inL1Arr  [ENTRIES];
  logic [TAG_W-1:0]    tagArr   [ENTRIES];
  logic [VBITS-1:0]    vidxArr  [ENTRIES];
  logic [DATA_W-1:0]   dataArr  [ENTRIES];

  logic [L2_IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0]    reqTag;
  logic [L2_IDX_W-1:0] evIdx;
  logic [TAG_W-1:0]    evTag;
  logic [ENTRIES-1:0]  evictHitVec;

  assign reqIdx = reqPa[L2_IDX_W-1:0];
  assign reqTag = reqPa[PA_W-1:L2_IDX_W];
  assign evIdx  = evictPa[L2_IDX_W-1:0];
  assign evTag  = evictPa[PA_W-1:L2_IDX_W];

  // Per-entry match of an L1 eviction report
  for (genvar g = 0; g < ENTRIES; g++) begin : gEvict
    assign evictHitVec[g] = evictValid && (evIdx == L2_IDX_W'(g))
                            && validArr[g] && (tagArr[g] == evTag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPa   <= '0;
      reqVidx <= '0;
    end else if (strobe.captureReq) begin
      reqPa   <= reqPaIn;
      reqVidx <= reqVidxIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validArr[i] <= 1'b0;
        inL1Arr[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (evictHitVec[i]) inL1Arr[i] <= 1'b0;
      end
      if (strobe.fillLine) begin
        validArr[reqIdx] <= 1'b1;
        tagArr[reqIdx]   <= reqTag;
        dataArr[reqIdx]  <= memRespData;
        inL1Arr[reqIdx]  <= 1'b0;
      end
      if (strobe.clearInL1) begin
        inL1Arr[reqIdx] <= 1'b0;
      end
      if (strobe.markInL1) begin
        inL1Arr[reqIdx] <= 1'b1;
        vidxArr[reqIdx] <= reqVidx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagArr[i]  <= '0;
        vidxArr[i] <= '0;
        dataArr[i] <= '0;
      end
    end
  end

  assign lookupHit   = validArr[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign entryInL1   = validArr[reqIdx] && inL1Arr[reqIdx];
  assign vidxDiffers = (vidxArr[reqIdx] != reqVidx);
  assign lineAddr    = reqPa;
  assign purgeSet    = {vidxArr[reqIdx], reqPa[OFF_IDX_W-1:0]};
  assign fillSet     = {reqVidx, reqPa[OFF_IDX_W-1:0]};
  assign lineData    = dataArr[reqIdx];

  // A line is only returned to L1 while the L2 holds it
  assert_mark_present_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markInL1 |-> lookupHit);

  // After a fill the requested line hits
  assert_fill_hits_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillLine |=> lookupHit);

  // After returning a line, the entry is recorded as in L1
  assert_marked_inl1_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markInL1 |=> entryInL1 || $past(evictValid));

endmodule

// File: rtl/l2ag_control.sv
module l2ag_control
  import l2ag_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      lookupHit,
  input  logic      entryInL1,
  input  logic      vidxDiffers,
  output logic      invValid,
  input  logic      invAck,
  output logic      memReqValid,
  input  logic      memReqReady,
  input  logic      memRespValid,
  output logic      respValid,
  output dpStrobe_t strobe
);

  ctlState_t state, stateNext;
  logic      memSent;
  logic      wasHit;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    invValid    = 1'b0;
    memReqValid = 1'b0;
    respValid   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          stateNext         = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lookupHit) begin
          stateNext = (entryInL1 && vidxDiffers) ? ST_PURGE : ST_RESPOND;
        end else begin
          stateNext = entryInL1 ? ST_PURGE : ST_MEMFETCH;
        end
      end
      ST_PURGE: begin
        invValid = 1'b1;
        if (invAck) begin
          strobe.clearInL1 = 1'b1;
          stateNext        = wasHit ? ST_RESPOND : ST_MEMFETCH;
        end
      end
      ST_MEMFETCH: begin
        memReqValid = !memSent;
        if (memSent && memRespValid) begin
          strobe.fillLine = 1'b1;
          stateNext       = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        respValid       = 1'b1;
        strobe.markInL1 = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      memSent <= 1'b0;
      wasHit  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_LOOKUP) wasHit <= lookupHit;
      if (state != ST_MEMFETCH)            memSent <= 1'b0;
      else if (memReqValid && memReqReady) memSent <= 1'b1;
    end
  end

  // Single outstanding request
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_resp_not_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);

  // Purge completes before the memory read
  assert_no_inv_mem_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(invValid && memReqValid));

  assert_inv_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invAck) |=> invValid);

  assert_no_resp_in_inv_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(respValid && invValid));

  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // Alias hit never touches memory
  assert_alias_no_mem_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP && lookupHit) |=> !memReqValid);

endmodule

// File: rtl/l2_alias_guard.sv
module l2_alias_guard
  import l2ag_pkg::*;
#(
  parameter int PA_W      = 12,
  parameter int L2_IDX_W  = 4,
  parameter int OFF_IDX_W = 2,
  parameter int VBITS     = 2,
  parameter int DATA_W    = 32,
  localparam int SET_W    = VBITS + OFF_IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [PA_W-1:0]   reqPa,
  input  logic [VBITS-1:0]  reqVidx,
  input  logic              evictValid,
  input  logic [PA_W-1:0]   evictPa,
  output logic              invValid,
  output logic [SET_W-1:0]  invSet,
  input  logic              invAck,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic [SET_W-1:0]  respSet
);

  dpStrobe_t strobe;
  logic      lookupHit;
  logic      entryInL1;
  logic      vidxDiffers;

  l2ag_control uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .lookupHit    (lookupHit),
    .entryInL1    (entryInL1),
    .vidxDiffers  (vidxDiffers),
    .invValid     (invValid),
    .invAck       (invAck),
    .memReqValid  (memReqValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .respValid    (respValid),
    .strobe       (strobe)
  );

  l2ag_datapath #(
    .PA_W      (PA_W),
    .L2_IDX_W  (L2_IDX_W),
    .OFF_IDX_W (OFF_IDX_W),
    .VBITS     (VBITS),
    .DATA_W    (DATA_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqPaIn     (reqPa),
    .reqVidxIn   (reqVidx),
    .memRespData (memRespData),
    .evictValid  (evictValid),
    .evictPa     (evictPa),
    .lookupHit   (lookupHit),
    .entryInL1   (entryInL1),
    .vidxDiffers (vidxDiffers),
    .lineAddr    (memReqAddr),
    .purgeSet    (invSet),
    .fillSet     (respSet),
    .lineData    (respData)
  );

  assert_inv_set_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invAck) |=> $stable(invSet));

  assert_mem_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

endmodule

// File: tb/l2_alias_guard_test.sv
module l2_alias_guard_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady;
  logic [11:0] reqPa;
  logic [1:0]  reqVidx;
  logic        evictValid;
  logic [11:0] evictPa;
  logic        invValid;
  logic [3:0]  invSet;
  logic        invAck;
  logic        memReqValid, memReqReady;
  logic [11:0] memReqAddr;
  logic        memRespValid;
  logic [31:0] memRespData;
  logic        respValid;
  logic [31:0] respData;
  logic [3:0]  respSet;

  int checks = 0;
  int failures = 0;

  // Bench model of the L2 entries
  logic       mValid [16];
  logic       mInL1  [16];
  logic [7:0] mTag   [16];
  logic [1:0] mVidx  [16];

  always #10 clk = ~clk; // 50 MHz

  l2_alias_guard uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPa(reqPa), .reqVidx(reqVidx), .evictValid(evictValid), .evictPa(evictPa),
    .invValid(invValid), .invSet(invSet), .invAck(invAck),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .respValid(respValid), .respData(respData), .respSet(respSet)
  );

  function automatic logic [31:0] memData(input logic [11:0] pa);
    return ({pa, 20'h0} ^ (32'(pa) * 32'h045d9f3b) ^ 32'h5a5a1234);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doEvict(input logic [11:0] pa);
    @(negedge clk);
    evictValid = 1'b1;
    evictPa    = pa;
    if (mValid[pa[3:0]] && mTag[pa[3:0]] == pa[11:4]) mInL1[pa[3:0]] = 1'b0;
    @(negedge clk);
    evictValid = 1'b0;
  endtask

  task automatic doAccess(input logic [11:0] pa, input logic [1:0] vidx,
                          input string invReq);
    logic [3:0]  idx = pa[3:0];
    bit          expHit, expInv, expMem;
    logic [3:0]  expInvSet;
    bit          sawInv = 0, sawMem = 0, invFirst = 0, done = 0;
    bit          badStable = 0, badOverlap = 0, badReady = 0;
    logic [3:0]  invSeen = '0;
    logic [11:0] memAddrSeen = '0;
    logic [31:0] gotData = '0;
    logic [3:0]  gotSet = '0;
    bit          memPending = 0;
    int          memCnt = 0, invWait = 0;
    int          invDelay = $urandom % 3;

    expHit    = mValid[idx] && mTag[idx] == pa[11:4];
    expInv    = mValid[idx] && mInL1[idx] && (!expHit || mVidx[idx] != vidx);
    expMem    = !expHit;
    expInvSet = {mVidx[idx], pa[1:0]};

    @(negedge clk);
    check(reqReady == 1'b1, "R7", "reqReady when idle", reqReady, 1);
    reqValid = 1'b1;
    reqPa    = pa;
    reqVidx  = vidx;
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 0; cyc < 200 && !done; cyc++) begin
      if (reqReady) badReady = 1;
      if (invValid) begin
        if (!sawInv) begin
          sawInv   = 1;
          invSeen  = invSet;
          invFirst = !sawMem;
        end else if (invSet != invSeen) badStable = 1;
        if (respValid) badOverlap = 1;
        invAck = (invWait >= invDelay);
        invWait++;
      end else begin
        invAck = 1'b0;
      end
      memRespValid = 1'b0;
      if (memPending) begin
        if (memCnt == 0) begin
          memRespValid = 1'b1;
          memRespData  = memData(pa);
          memPending   = 0;
        end else memCnt--;
      end
      memReqReady = 1'($urandom % 2);
      if (memReqValid && memReqReady) begin
        sawMem      = 1;
        memAddrSeen = memReqAddr;
        memPending  = 1;
        memCnt      = $urandom % 3;
      end
      if (respValid) begin
        done    = 1;
        gotData = respData;
        gotSet  = respSet;
      end else begin
        @(negedge clk);
      end
    end
    invAck = 1'b0; memReqReady = 1'b0; memRespValid = 1'b0;

    check(done, "R7", "response arrived (watchdog)", done, 1);
    check(!badReady, "R7", "reqReady low while busy", badReady, 0);
    check(sawInv == expInv, invReq, "invalidate issued", sawInv, expInv);
    if (expInv && sawInv) begin
      check(invSeen == expInvSet, expHit ? "R4" : "R5", "invSet", invSeen, expInvSet);
      check(invFirst, "R5", "invalidate before memory read", invFirst, 1);
    end
    check(!badStable && !badOverlap, "R9", "inv hold / no resp overlap",
          {badStable, badOverlap}, 0);
    check(sawMem == expMem, expHit ? "R3" : "R2", "memory read issued", sawMem, expMem);
    if (expMem && sawMem)
      check(memAddrSeen == pa, "R2", "memReqAddr", memAddrSeen, pa);
    check(gotData == memData(pa), "R8", "respData", gotData, memData(pa));
    check(gotSet == {vidx, pa[1:0]}, "R2", "respSet", gotSet, {vidx, pa[1:0]});

    mValid[idx] = 1'b1;
    mTag[idx]   = pa[11:4];
    mInL1[idx]  = 1'b1;
    mVidx[idx]  = vidx;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 0; mInL1[i] = 0; mTag[i] = '0; mVidx[i] = '0;
    end
    rstN = 1'b0; reqValid = 0; reqPa = '0; reqVidx = '0;
    evictValid = 0; evictPa = '0; invAck = 0; memReqReady = 0;
    memRespValid = 0; memRespData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    check({invValid, memReqValid, respValid} == 3'b000, "R1", "outputs idle after reset",
          {invValid, memReqValid, respValid}, 0);

    // Directed corner cases on L2 index 3
    doAccess(12'h013, 2'd1, "R1");  // cold miss, R2
    doAccess(12'h013, 2'd1, "R3");  // same bits hit
    doAccess(12'h013, 2'd2, "R4");  // alias hit: purge set {2'd1,2'd3}
    doAccess(12'h023, 2'd0, "R5");  // conflict miss, victim in L1
    doEvict(12'h023);               // matching eviction report
    doAccess(12'h023, 2'd3, "R6");  // no purge needed
    doEvict(12'h033);               // eviction report with no matching entry
    doAccess(12'h023, 2'd1, "R10"); // purge still needed
    doAccess(12'h013, 2'd0, "R5");  // refetch, data again from memory (R8)

    // Random mix from a small address pool
    for (int n = 0; n < 400; n++) begin
      logic [11:0] pa;
      pa = {6'd0, 2'($urandom % 4), 4'($urandom % 4)};
      if ($urandom % 5 == 0) doEvict({6'd0, 2'($urandom % 4), 4'($urandom % 4)});
      doAccess(pa, 2'($urandom % 4), "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule